// File: doc/BRIEF.md
# Control-Word Chained Datapath

This block is a small datapath with no instruction decoding of its own. Each cycle a wide control word and a separate constant value arrive on its inputs. The control word sets every multiplexer select, bus driver, register enable and register-file index directly. The datapath holds a sixteen-entry register file with two read ports, a multiplier whose product is registered, an adder and a logical shifter. These units are tied together by exposed buses and multiplexers. An external sequencer, outside this block, supplies the control words.

The adder output can feed the shifter in the same cycle, so an add and a shift finish together. The registered product can reach the adder directly without first being written to the register file. A single write-back bus returns one of three sources to the register file: the shifter, the product register, or the shift-amount bus, which can carry the constant. A combinational peek port exposes any register-file entry for observation. A bus that no control field selects carries zero.

Top module: `cwdp_top`

## Requirements
- R1: After reset all sixteen register-file entries read as zero and the product register holds zero.
- R2: Control word bit layout: rdA=[3:0], rdB=[7:4], prodLoad=[8], addSel=[10:9], shSel=[12:11], amtSel=[14:13], shRight=[15], wbSel=[17:16], wrEn=[18], wrIdx=[22:19].
- R3: Read bus A carries entry rdA and read bus B carries entry rdB. When prodLoad=1 the product register captures the low 32 bits of busA*busB at the clock edge. When prodLoad=0 it holds its value.
- R4: The adder left input is zero for addSel=0, bus A for 1, the product register for 2, and zero for 3. The right input is bus B. The sum is taken modulo 2^32.
- R5: The shifter left input is zero for shSel=0, the adder output of the same cycle for 1, bus A for 2, and zero for 3. The amount bus carries zero for amtSel=0, the constant input for 1, bus B for 2, and zero for 3. The shift is logical, by the low 5 bits of the amount bus: left when shRight=0 and right when shRight=1.
- R6: The write-back bus carries zero for wbSel=0, the shifter for 1, the product register for 2, and the amount bus for 3. When wrEn=1, entry wrIdx takes that value at the clock edge, and the next cycle's reads already see it.
- R7: When wrEn=0 no register-file entry changes, whatever the other fields say.
- R8: peekData shows entry peekIdx combinationally.
- R9: A cycle that loads the product register and also uses it sees the previous product; the new product is usable from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cwWord | input | 23 | Control word for the current cycle |
| cwConst | input | 32 | Constant field that accompanies the control word |
| peekIdx | input | 4 | Register-file entry to observe |
| peekData | output | 32 | Contents of entry peekIdx |

## Verification
Every internal fault in this block reaches the ports through the register file. A wrong select, a stale product or a lost write appears on peekData one cycle after the control word that wrote the affected entry, because the write lands on that clock edge. A fault in the product register stays hidden until a later control word routes the product onto the write-back bus, either directly or through the adder. For that reason the stimulus routes every source into the register file and reads it back at once. This includes the cycle in which the product register is loaded and used together.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
  localparam int DATA_W = 32;
  localparam int RF_N   = 16;
  localparam int IDX_W  = $clog2(RF_N);
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int SEL_W  = 2;

  // control word field positions (R2)
  localparam int RDA_LSB    = 0;
  localparam int RDB_LSB    = RDA_LSB + IDX_W;
  localparam int PLOAD_BIT  = RDB_LSB + IDX_W;
  localparam int ADDSEL_LSB = PLOAD_BIT + 1;
  localparam int SHSEL_LSB  = ADDSEL_LSB + SEL_W;
  localparam int AMTSEL_LSB = SHSEL_LSB + SEL_W;
  localparam int SHDIR_BIT  = AMTSEL_LSB + SEL_W;
  localparam int WBSEL_LSB  = SHDIR_BIT + 1;
  localparam int WREN_BIT   = WBSEL_LSB + SEL_W;
  localparam int WRIDX_LSB  = WREN_BIT + 1;
  localparam int CW_W       = WRIDX_LSB + IDX_W;

  typedef struct packed {
    logic [IDX_W-1:0] rdA;
    logic [IDX_W-1:0] rdB;
    logic [IDX_W-1:0] wrIdx;
    logic             wrEn;
    logic             prodLoad;
    logic             shRight;
    logic             addFromBusA;
    logic             addFromProd;
    logic             shFromAdd;
    logic             shFromBusA;
    logic             amtFromConst;
    logic             amtFromBusB;
    logic             wbFromShift;
    logic             wbFromProd;
    logic             wbFromAmt;
  } strobe_t;
endpackage

// File: rtl/cwdp_ctrl.sv
module cwdp_ctrl
  import cwdp_pkg::*;
(
  input  logic [CW_W-1:0] cwWord,
  output strobe_t         strb
);
  logic [SEL_W-1:0] addSel, shSel, amtSel, wbSel;

  assign addSel = cwWord[ADDSEL_LSB +: SEL_W];
  assign shSel  = cwWord[SHSEL_LSB  +: SEL_W];
  assign amtSel = cwWord[AMTSEL_LSB +: SEL_W];
  assign wbSel  = cwWord[WBSEL_LSB  +: SEL_W];

  always_comb begin
    strb          = '0;
    strb.rdA      = cwWord[RDA_LSB +: IDX_W];
    strb.rdB      = cwWord[RDB_LSB +: IDX_W];
    strb.wrIdx    = cwWord[WRIDX_LSB +: IDX_W];
    strb.wrEn     = cwWord[WREN_BIT];
    strb.prodLoad = cwWord[PLOAD_BIT];
    strb.shRight  = cwWord[SHDIR_BIT];
    case (addSel)
      2'd1:    strb.addFromBusA = 1'b1;
      2'd2:    strb.addFromProd = 1'b1;
      default: ;
    endcase
    case (shSel)
      2'd1:    strb.shFromAdd = 1'b1;
      2'd2:    strb.shFromBusA = 1'b1;
      default: ;
    endcase
    case (amtSel)
      2'd1:    strb.amtFromConst = 1'b1;
      2'd2:    strb.amtFromBusB = 1'b1;
      default: ;
    endcase
    case (wbSel)
      2'd1:    strb.wbFromShift = 1'b1;
      2'd2:    strb.wbFromProd = 1'b1;
      2'd3:    strb.wbFromAmt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cwdp_regfile.sv
module cwdp_regfile
  import cwdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  peekIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] peekData
);
  logic [DATA_W-1:0] entryView [RF_N];

  for (genvar g = 0; g < RF_N; g++) begin : g_entry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wrEn && (wrIdx == IDX_W'(g)))
        q <= wrData;
    end
    assign entryView[g] = q;
  end

  assign rdDataA  = entryView[rdIdxA];
  assign rdDataB  = entryView[rdIdxB];
  assign peekData = entryView[peekIdx];
endmodule

// File: rtl/cwdp_path.sv
module cwdp_path
  import cwdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] constVal,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] wbVal,
  output logic [DATA_W-1:0] prodVal
);
  logic [DATA_W-1:0] busA, busB;
  logic [DATA_W-1:0] addLeft, addOut;
  logic [DATA_W-1:0] shLeft, amtBus, shOut;
  logic [DATA_W-1:0] prodQ, prodNext;

  cwdp_regfile u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdIdxA   (strb.rdA),
    .rdIdxB   (strb.rdB),
    .peekIdx  (peekIdx),
    .wrEn     (strb.wrEn),
    .wrIdx    (strb.wrIdx),
    .wrData   (wbVal),
    .rdDataA  (busA),
    .rdDataB  (busB),
    .peekData (peekData)
  );

  // multiplier, low half kept, registered
  assign prodNext = busA * busB;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prodQ <= '0;
    else if (strb.prodLoad)
      prodQ <= prodNext;
  end

  // undriven buses collapse to zero through AND-OR selection
  assign addLeft = ({DATA_W{strb.addFromBusA}} & busA)
                 | ({DATA_W{strb.addFromProd}} & prodQ);
  assign addOut  = addLeft + busB;

  assign shLeft  = ({DATA_W{strb.shFromAdd}}  & addOut)
                 | ({DATA_W{strb.shFromBusA}} & busA);
  assign amtBus  = ({DATA_W{strb.amtFromConst}} & constVal)
                 | ({DATA_W{strb.amtFromBusB}}  & busB);
  assign shOut   = strb.shRight ? (shLeft >> amtBus[AMT_W-1:0])
                                : (shLeft << amtBus[AMT_W-1:0]);

  assign wbVal   = ({DATA_W{strb.wbFromShift}} & shOut)
                 | ({DATA_W{strb.wbFromProd}}  & prodQ)
                 | ({DATA_W{strb.wbFromAmt}}   & amtBus);
  assign prodVal = prodQ;
endmodule

// File: rtl/cwdp_top.sv
module cwdp_top
  import cwdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   cwWord,
  input  logic [DATA_W-1:0] cwConst,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [DATA_W-1:0] peekData
);
  strobe_t           strb;
  logic [DATA_W-1:0] wbVal;
  logic [DATA_W-1:0] prodVal;

  cwdp_ctrl u_ctrl (
    .cwWord (cwWord),
    .strb   (strb)
  );

  cwdp_path u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .constVal (cwConst),
    .peekIdx  (peekIdx),
    .peekData (peekData),
    .wbVal    (wbVal),
    .prodVal  (prodVal)
  );
endmodule

// File: rtl/cwdp_chk.sv
module cwdp_chk
  import cwdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CW_W-1:0]   cwWord,
  input logic [IDX_W-1:0]  peekIdx,
  input logic [DATA_W-1:0] peekData,
  input strobe_t           strb,
  input logic [DATA_W-1:0] wbVal,
  input logic [DATA_W-1:0] prodVal
);
  logic             wrEnW, pLoadW;
  logic [IDX_W-1:0] wrIdxW;
  assign wrEnW  = cwWord[WREN_BIT];
  assign pLoadW = cwWord[PLOAD_BIT];
  assign wrIdxW = cwWord[WRIDX_LSB +: IDX_W];

  assert_reset_prod_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> prodVal == '0);

  assert_add_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.addFromBusA, strb.addFromProd}));

  assert_shift_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.shFromAdd, strb.shFromBusA}) &&
    $onehot0({strb.amtFromConst, strb.amtFromBusB}));

  assert_wb_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.wbFromShift || strb.wbFromProd || strb.wbFromAmt) |-> wbVal == '0);

  assert_wb_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrEnW) && ($past(wrIdxW) == peekIdx) && $stable(peekIdx))
      |-> peekData == $past(wbVal));

  assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wrEnW) && $stable(peekIdx)) |-> $stable(peekData));

  assert_prod_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pLoadW) |-> $stable(prodVal));
endmodule

bind cwdp_top cwdp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cwWord   (cwWord),
  .peekIdx  (peekIdx),
  .peekData (peekData),
  .strb     (strb),
  .wbVal    (wbVal),
  .prodVal  (prodVal)
);

// File: tb/cwdp_top_tb.sv
module cwdp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] cwWord = '0;
  logic [31:0] cwConst = '0;
  logic [3:0]  peekIdx = '0;
  logic [31:0] peekData;

  always #5 clk = ~clk;

  cwdp_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cwWord   (cwWord),
    .cwConst  (cwConst),
    .peekIdx  (peekIdx),
    .peekData (peekData)
  );

  typedef struct {
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sbQ[$];
  int          pending = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [31:0] mRf [16];
  logic [31:0] mProd;

  // R2 layout built independently
  function automatic logic [22:0] mkCw(int rdA, int rdB, int pLoad, int addSel,
      int shSel, int amtSel, int shRight, int wbSel, int wrEn, int wrIdx);
    logic [22:0] w;
    w = '0;
    w[3:0]   = 4'(rdA);
    w[7:4]   = 4'(rdB);
    w[8]     = 1'(pLoad);
    w[10:9]  = 2'(addSel);
    w[12:11] = 2'(shSel);
    w[14:13] = 2'(amtSel);
    w[15]    = 1'(shRight);
    w[17:16] = 2'(wbSel);
    w[18]    = 1'(wrEn);
    w[22:19] = 4'(wrIdx);
    return w;
  endfunction

  // driver: one control word, reference model updated at the edge
  task automatic stepCw(int rdA, int rdB, int pLoad, int addSel, int shSel,
      int amtSel, int shRight, int wbSel, int wrEn, int wrIdx, logic [31:0] k);
    logic [31:0] bA, bB, aL, sum, sL, amt, sh, wb;
    @(negedge clk);
    cwWord  = mkCw(rdA, rdB, pLoad, addSel, shSel, amtSel, shRight, wbSel, wrEn, wrIdx);
    cwConst = k;
    bA  = mRf[rdA];
    bB  = mRf[rdB];
    aL  = (addSel == 1) ? bA : (addSel == 2) ? mProd : 32'h0;
    sum = aL + bB;
    sL  = (shSel == 1) ? sum : (shSel == 2) ? bA : 32'h0;
    amt = (amtSel == 1) ? k : (amtSel == 2) ? bB : 32'h0;
    sh  = shRight ? (sL >> amt[4:0]) : (sL << amt[4:0]);
    wb  = (wbSel == 1) ? sh : (wbSel == 2) ? mProd : (wbSel == 3) ? amt : 32'h0;
    @(posedge clk);
    if (wrEn != 0) mRf[wrIdx] = wb;
    if (pLoad != 0) mProd = bA * bB;
    #1;
    cwWord  = '0;
    cwConst = '0;
  endtask

  task automatic expectReg(int idx, logic [31:0] exp, string tag);
    item_t it;
    it.idx = idx;
    it.exp = exp;
    it.tag = tag;
    sbQ.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  // monitor: pops expected items and compares at the peek port
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        peekIdx = 4'(it.idx);
        #1;
        checks++;
        if (peekData !== it.exp) begin
          errors++;
          $display("FAIL %s: entry %0d actual %h expected %h", it.tag, it.idx, peekData, it.exp);
        end
        pending--;
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mRf[i] = '0;
    mProd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R8: every entry zero after reset, read through the peek port
    for (int i = 0; i < 16; i++) expectReg(i, 32'h0, "R1_R8 reset");

    // R6: seed through amount bus (amtSel=1 constant, wbSel=3)
    stepCw(0, 0, 0, 0, 0, 1, 0, 3, 1, 1, 32'h1234_5678);
    stepCw(0, 0, 0, 0, 0, 1, 0, 3, 1, 2, 32'h0000_0003);
    stepCw(0, 0, 0, 0, 0, 1, 0, 3, 1, 3, 32'h0000_0010);
    stepCw(0, 0, 0, 0, 0, 1, 0, 3, 1, 4, 32'hFFFF_FFF8);
    expectReg(1, 32'h1234_5678, "R6 seed");
    expectReg(4, 32'hFFFF_FFF8, "R6 seed");

    // R6: write visible to the very next cycle's read
    stepCw(0, 0, 0, 0, 0, 1, 0, 3, 1, 7, 32'h0000_0009);
    stepCw(7, 0, 0, 0, 2, 0, 0, 1, 1, 8, 32'h0);
    expectReg(8, 32'h0000_0009, "R6 next-cycle read");

    // R5: bus A shifted left by constant 1
    stepCw(1, 0, 0, 0, 2, 1, 0, 1, 1, 1, 32'h1);
    expectReg(1, 32'h2468_ACF0, "R5 left shift");

    // R4/R5 chain: (r3+r4) << low5(0x22) in one cycle, sum wraps
    stepCw(3, 4, 0, 1, 1, 1, 0, 1, 1, 9, 32'h0000_0022);
    expectReg(9, 32'h0000_0020, "R4_R5 chain");

    // R5: right shift by bus B, and logical fill
    stepCw(1, 2, 0, 0, 2, 2, 1, 1, 1, 10, 32'h0);
    expectReg(10, 32'h048D_159E, "R5 right shift");
    stepCw(4, 2, 0, 0, 2, 2, 1, 1, 1, 11, 32'h0);
    expectReg(11, 32'h1FFF_FFFF, "R5 logical right");

    // R9: load and use in the same cycle sees old product (zero)
    stepCw(1, 2, 1, 0, 0, 0, 0, 2, 1, 12, 32'h0);
    expectReg(12, 32'h0, "R9 load-use");
    // R3: product usable next cycle
    stepCw(0, 0, 0, 0, 0, 0, 0, 2, 1, 13, 32'h0);
    expectReg(13, 32'h6D3A_06D0, "R3 product");
    // R4: product forwarded into adder, added to bus B
    stepCw(0, 2, 0, 2, 1, 0, 0, 1, 1, 14, 32'h0);
    expectReg(14, 32'h6D3A_06D3, "R4 forward");
    // R3: product holds with prodLoad=0
    stepCw(4, 4, 0, 0, 0, 0, 0, 2, 1, 15, 32'h0);
    expectReg(15, 32'h6D3A_06D0, "R3 hold");
    // R3: low 32 bits of an overflowing product
    stepCw(4, 4, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    stepCw(0, 0, 0, 0, 0, 0, 0, 2, 1, 15, 32'h0);
    expectReg(15, 32'h0000_0040, "R3 low product");

    // R7: full-looking control word but wrEn=0 leaves entries alone
    stepCw(4, 4, 0, 1, 1, 1, 0, 1, 0, 1, 32'h5);
    expectReg(1, 32'h2468_ACF0, "R7 no write");

    // R4: addSel=3 gives zero left operand
    stepCw(4, 2, 0, 3, 1, 0, 0, 1, 1, 3, 32'h0);
    expectReg(3, 32'h0000_0003, "R4 zero left");
    // R5: shSel=3 gives zero
    stepCw(4, 0, 0, 0, 3, 0, 0, 1, 1, 5, 32'h0);
    expectReg(5, 32'h0, "R5 zero left");
    // R6: wbSel=0 writes zero
    stepCw(1, 0, 0, 0, 2, 0, 0, 0, 1, 2, 32'h0);
    expectReg(2, 32'h0, "R6 zero write");

    // final sweep against the model
    for (int i = 0; i < 16; i++) expectReg(i, mRf[i], "R8 sweep");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule